// File: doc/BRIEF.md
# Static LCD Backplane Segment Driver

This block drives a three-and-a-half digit, direct-drive liquid crystal panel. It takes digit values in BCD and a polarity flag from a result latch. A slow square wave for the common backplane is made by dividing the oscillator clock. Every segment output is the backplane level when the segment is dark and its inverse when the segment is lit, so over a full period no DC voltage is left across any segment.

The three lower positions have full seven-segment outputs. The leading half digit has a single output that lights its two right-hand bars together, and there is a separate output for the minus sign. An overrange flag shows a lone leading "1" with the lower digits blank. A lamp-test input lights every segment. While it is set, the segment lines sit at a constant high level instead of switching against the backplane.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp` is a 50% duty square wave that changes level once every DIV_RATIO/2 clock cycles, so its period is DIV_RATIO cycles (800 by default).
- R2: While `rst` is high, `bp` and every segment output are low after the next clock edge. After `rst` falls, the first rising edge of `bp` comes on the DIV_RATIO/2-th clock edge.
- R3: Outside lamp test, a dark segment output equals `bp` and a lit segment output equals the inverse of `bp`. Segment outputs and `bp` are registered on the same clock edge.
- R4: `seg_digits` holds DIGITS groups of 7 bits, with the units digit in bits [6:0]. Within a group, bit 0 is segment a and bit 6 is segment g, in the order a,b,c,d,e,f,g. BCD 0..9 light the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F, so both 6 and 9 show their tail bar.
- R5: A digit with a BCD value from 10 to 15 is blank: all seven of its outputs equal `bp`.
- R6: `seg_lead` is lit when `lead_one` is 1. `seg_minus` is lit when `neg` is 1, and this holds even when all digits are zero. Zero digits are never blanked, so a zero result shows all lower digits as the pattern 0x3F.
- R7: When `ovr` is 1, the lower digits are blank, `seg_lead` is lit and `seg_minus` follows `neg`.
- R8: When `lamp_test` is 1, every segment output (all of `seg_digits`, `seg_lead`, `seg_minus`) is a constant 1, whatever `bp`, `ovr` or the digit inputs are. `bp` keeps toggling.
- R9: A change on any data input shows at the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_bcd | input | DIGITS*4 | Latched BCD digits, units digit in bits [3:0] |
| lead_one | input | 1 | Leading half digit shows "1" |
| neg | input | 1 | Latched polarity, 1 means negative |
| ovr | input | 1 | Overrange flag |
| lamp_test | input | 1 | Light every segment with a constant level |
| bp | output | 1 | Backplane square wave |
| seg_digits | output | DIGITS*7 | Segment drives of the lower digits |
| seg_lead | output | 1 | Combined b/c drive of the half digit |
| seg_minus | output | 1 | Minus-sign drive |

## Verification
Segment outputs follow a data input change one clock edge later. The bench drives inputs on the falling edge and reads the outputs at the next falling edge, one registered stage later. It reads `bp` in that same sample and forms the expected segment word as the lit pattern XORed with the sampled backplane, because both come from the same edge. Timing checks on the backplane count falling edges, from reset release to the first rise (DIV_RATIO/2 edges) and between two later changes (also DIV_RATIO/2). Lit-versus-dark phase is checked on both backplane levels by holding a pattern across a backplane change.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg7_t;
  localparam seg7_t SEG_DARK = '0;
endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int HALF_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  output logic bp,
  output logic bp_next
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == LAST);
  assign bp_next = bp ^ wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      bp  <= bp_next;
    end
  end
endmodule

// File: rtl/lcd_digit_decoder.sv
module lcd_digit_decoder
  import lcd_drv_pkg::*;
(
  input  logic [3:0] bcd,
  input  logic       blank,
  output seg7_t      seg
);
  always_comb begin
    seg = SEG_DARK;
    if (!blank) begin
      unique case (bcd)
        4'd0:    seg = 7'h3F;
        4'd1:    seg = 7'h06;
        4'd2:    seg = 7'h5B;
        4'd3:    seg = 7'h4F;
        4'd4:    seg = 7'h66;
        4'd5:    seg = 7'h6D;
        4'd6:    seg = 7'h7D;
        4'd7:    seg = 7'h07;
        4'd8:    seg = 7'h7F;
        4'd9:    seg = 7'h6F;
        default: seg = SEG_DARK;
      endcase
    end
  end
endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
  import lcd_drv_pkg::*;
#(
  parameter int DIV_RATIO = 800,
  parameter int DIGITS    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIGITS*4-1:0]   digits_bcd,
  input  logic                  lead_one,
  input  logic                  neg,
  input  logic                  ovr,
  input  logic                  lamp_test,
  output logic                  bp,
  output logic [DIGITS*SEG_W-1:0] seg_digits,
  output logic                  seg_lead,
  output logic                  seg_minus
);
  localparam int HALF_CYC = DIV_RATIO / 2;
  localparam int NSEG     = DIGITS * SEG_W;

  logic            bp_next;
  logic [NSEG-1:0] lit_digits;
  logic            lit_lead;
  logic            lit_minus;
  logic [NSEG-1:0] drv_digits;
  logic            drv_lead;
  logic            drv_minus;

  lcd_bp_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk    (clk),
    .rst    (rst),
    .bp     (bp),
    .bp_next(bp_next)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    lcd_digit_decoder u_dec (
      .bcd  (digits_bcd[d*4 +: 4]),
      .blank(ovr),
      .seg  (lit_digits[d*SEG_W +: SEG_W])
    );
  end

  assign lit_lead  = lead_one | ovr;
  assign lit_minus = neg;

  always_comb begin
    if (lamp_test) begin
      drv_digits = '1;
      drv_lead   = 1'b1;
      drv_minus  = 1'b1;
    end else begin
      drv_digits = lit_digits ^ {NSEG{bp_next}};
      drv_lead   = lit_lead ^ bp_next;
      drv_minus  = lit_minus ^ bp_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_digits <= '0;
      seg_lead   <= 1'b0;
      seg_minus  <= 1'b0;
    end else begin
      seg_digits <= drv_digits;
      seg_lead   <= drv_lead;
      seg_minus  <= drv_minus;
    end
  end
endmodule

// File: rtl/lcd_static_checker.sv
module lcd_static_checker #(
  parameter int DIV_RATIO = 800,
  parameter int DIGITS    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [DIGITS*4-1:0] digits_bcd,
  input logic                lead_one,
  input logic                neg,
  input logic                ovr,
  input logic                lamp_test,
  input logic                bp,
  input logic [DIGITS*7-1:0] seg_digits,
  input logic                seg_lead,
  input logic                seg_minus
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] tick;
  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= (tick == LAST) ? '0 : tick + 1'b1;
  end

  // R1
  bp_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick == LAST) |=> (bp != $past(bp)));

  // R1
  bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick != LAST) |=> $stable(bp));

  // R3
  minus_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !lamp_test |=> (seg_minus == ($past(neg) ^ bp)));

  // R7
  ovr_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr && !lamp_test) |=> ((seg_digits == {(DIGITS*7){bp}}) && (seg_lead == !bp)));

  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovr && !lamp_test && (digits_bcd[3:0] > 4'd9)) |=> (seg_digits[6:0] == {7{bp}}));

  // R8
  lamp_on_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_test |=> ((&seg_digits) && seg_lead && seg_minus));
endmodule

bind lcd_static_driver lcd_static_checker #(.DIV_RATIO(DIV_RATIO), .DIGITS(DIGITS)) u_chk (.*);

// File: tb/sim_lcd_static_driver.sv
module sim_lcd_static_driver;
  localparam int DIV_RATIO = 800;
  localparam int DIGITS    = 3;
  localparam int HALF      = DIV_RATIO / 2;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [DIGITS*4-1:0]   digits_bcd = '0;
  logic                  lead_one = 1'b0;
  logic                  neg = 1'b0;
  logic                  ovr = 1'b0;
  logic                  lamp_test = 1'b0;
  logic                  bp;
  logic [DIGITS*7-1:0]   seg_digits;
  logic                  seg_lead;
  logic                  seg_minus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd_static_driver #(.DIV_RATIO(DIV_RATIO), .DIGITS(DIGITS)) u0 (
    .clk(clk), .rst(rst), .digits_bcd(digits_bcd), .lead_one(lead_one),
    .neg(neg), .ovr(ovr), .lamp_test(lamp_test), .bp(bp),
    .seg_digits(seg_digits), .seg_lead(seg_lead), .seg_minus(seg_minus)
  );

  function automatic logic [6:0] dec7(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      4'd0: p = 7'h3F; 4'd1: p = 7'h06; 4'd2: p = 7'h5B; 4'd3: p = 7'h4F;
      4'd4: p = 7'h66; 4'd5: p = 7'h6D; 4'd6: p = 7'h7D; 4'd7: p = 7'h07;
      4'd8: p = 7'h7F; 4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction

  function automatic logic [DIGITS*7+1:0] expect_out(input logic b);
    logic [DIGITS*7-1:0] lit;
    logic ld, mn;
    if (lamp_test) return '1;
    for (int d = 0; d < DIGITS; d++)
      lit[d*7 +: 7] = ovr ? 7'h00 : dec7(digits_bcd[d*4 +: 4]);
    ld = lead_one | ovr;
    mn = neg;
    return {ld ^ b, mn ^ b, lit ^ {(DIGITS*7){b}}};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input string req);
    @(negedge clk);
    check(req, 64'({seg_lead, seg_minus, seg_digits}), 64'(expect_out(bp)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic b0;
    int seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    // R2 reset state
    check("R2 reset", 64'({bp, seg_lead, seg_minus, seg_digits}), 64'd0);
    rst = 1'b0;
    n = 0;
    while (!bp && n < DIV_RATIO * 2) begin
      @(negedge clk);
      n++;
    end
    // R2 first rise
    check("R2 first bp rise", 64'(n), 64'(HALF));
    // R1 half period
    n = 0;
    b0 = bp;
    while (bp == b0 && n < DIV_RATIO * 2) begin
      @(negedge clk);
      n++;
    end
    check("R1 half period", 64'(n), 64'(HALF));
    n = 0;
    b0 = bp;
    while (bp == b0 && n < DIV_RATIO * 2) begin
      @(negedge clk);
      n++;
    end
    check("R1 second half period", 64'(n), 64'(HALF));

    // R6 zero with negative polarity, no blanking
    digits_bcd = '0; lead_one = 1'b0; neg = 1'b1;
    apply_and_check("R6 zero negative");
    check("R6 zero units lit", 64'(seg_digits[6:0] ^ {7{bp}}), 64'h3F);

    // R3 phase on both backplane levels
    digits_bcd = 12'h818; lead_one = 1'b1; neg = 1'b0;
    apply_and_check("R3 phase level a");
    b0 = bp;
    while (bp == b0) @(negedge clk);
    check("R3 phase level b", 64'({seg_lead, seg_minus, seg_digits}), 64'(expect_out(bp)));

    // R4 every code in the units position
    for (int v = 0; v < 10; v++) begin
      digits_bcd = {4'd0, 4'd0, 4'(v)};
      @(negedge clk);
      check("R4 decode", 64'(seg_digits[6:0] ^ {7{bp}}), 64'(dec7(4'(v))));
    end

    // R5 invalid codes blank
    digits_bcd = 12'hFAC;
    apply_and_check("R5 invalid blank");
    check("R5 blank units", 64'(seg_digits ^ {21{bp}}), 64'd0);

    // R7 overrange
    ovr = 1'b1; lead_one = 1'b0; neg = 1'b1; digits_bcd = 12'h123;
    apply_and_check("R7 overrange");
    ovr = 1'b0;

    // R8 lamp test over overrange and on both bp levels
    lamp_test = 1'b1; ovr = 1'b1;
    apply_and_check("R8 lamp test");
    b0 = bp;
    while (bp == b0) @(negedge clk);
    check("R8 lamp constant", 64'({seg_lead, seg_minus, seg_digits}), 64'h7F_FFFF);
    lamp_test = 1'b0; ovr = 1'b0;

    // R9 one-edge latency
    digits_bcd = 12'h456; neg = 1'b0; lead_one = 1'b0;
    @(negedge clk);
    digits_bcd = 12'h789;
    @(negedge clk);
    check("R9 latency", 64'(seg_digits ^ {21{bp}}),
          64'({dec7(4'd7), dec7(4'd8), dec7(4'd9)}));

    // R3 R4 R6 R7 R8 random mix
    for (int i = 0; i < 300; i++) begin
      digits_bcd = 12'($urandom);
      lead_one   = 1'($urandom);
      neg        = 1'($urandom);
      ovr        = ($urandom % 8) == 0;
      lamp_test  = ($urandom % 10) == 0;
      repeat ($urandom % 3) @(negedge clk);
      apply_and_check("R3 random");
    end
    finish_run();
  end
endmodule